// File: doc/BRIEF.md
# Sequential Integer Divider with Condition Flags

This block is the division unit of a processor execute stage. A one-cycle start strobe hands it a dividend, a divisor and an operation code. Some time later it returns a quotient and a remainder, each with its own write-enable, so that they can go to two separately addressed destinations. It also returns new values for the zero, sign and overflow condition flags, with a per-flag write mask. A one-cycle done pulse marks the result.

There are four operations: signed and unsigned division by a full word, and signed and unsigned division by a halfword. In the halfword forms only the divisor is narrowed. The dividend is always used at full width.

Ordinary divisions go through a restoring shift-and-subtract loop on operand magnitudes. The loop retires one quotient bit per clock, and the signs are fixed up at the end. Two outcomes are fixed and take one cycle, with no loop:
- A zero divisor raises overflow only and writes no result.
- The most negative dividend divided by minus one gives fixed results and fixed flags.

Top module: `div_flags_unit`

## Requirements
- R1: Operation code 1 (unsigned word) gives the unsigned quotient and remainder of the two 32-bit operands.
- R2: Operation code 0 (signed word) treats both operands as two's complement and truncates toward zero. The remainder takes the sign of the dividend.
- R3: Operation codes 2 and 3 take only divisor bits 15:0. Code 2 sign-extends them and code 3 zero-extends them. The dividend is used as a full 32-bit value (code 2 signed, code 3 unsigned).
- R4: For an ordinary result, the flag write mask (bit 0 zero, bit 1 sign, bit 2 overflow) is 3'b111 and overflow is 0. Zero is 1 exactly when the quotient is 0, and sign equals quotient bit 31.
- R5: When the effective divisor is zero, done comes one cycle after start. Both result write-enables are 0, the flag mask is 3'b100 and overflow is 1.
- R6: A signed operation (code 0 or 2) with dividend 0x80000000 and effective divisor 0xFFFFFFFF is done one cycle after start. It writes quotient 0x80000000 and remainder 0 with both enables, and flags zero=0, sign=1, overflow=1 with mask 3'b111.
- R7: An ordinary division raises done 32 cycles after the clock edge that accepts start, with busy high in between.
- R8: A start while busy is ignored: it neither changes the running result nor produces an extra done.
- R9: Done is a single-cycle pulse, and the result and flag write-enables are non-zero only while done is high. All of them are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted when not busy |
| op_i | input | 2 | 0 signed word, 1 unsigned word, 2 signed halfword divisor, 3 unsigned halfword divisor |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle result pulse |
| quot_o | output | 32 | Quotient |
| rem_o | output | 32 | Remainder |
| quot_we_o | output | 1 | Quotient write-enable |
| rem_we_o | output | 1 | Remainder write-enable |
| flag_z_o | output | 1 | New zero flag |
| flag_s_o | output | 1 | New sign flag |
| flag_ov_o | output | 1 | New overflow flag |
| flag_we_o | output | 3 | Flag write mask: bit 0 zero, bit 1 sign, bit 2 overflow |

## Verification
The assertions assume that operands and operation code are stable in the cycle start is sampled, and that no reset arrives in the middle of a division. The latency checks also assume that a start landing on a busy cycle is simply dropped, not queued. The bench drives inputs only at falling edges and holds start for exactly one cycle. It waits for busy to fall before each accepted request, and deliberately pulses start only inside a running division when testing R8.

// File: rtl/div_flags_pkg.sv
package div_flags_pkg;
   typedef enum logic [1:0] {
      DOP_SWORD = 2'd0,
      DOP_UWORD = 2'd1,
      DOP_SHALF = 2'd2,
      DOP_UHALF = 2'd3
   } div_op_e;

   localparam int FLG_Z  = 0;
   localparam int FLG_S  = 1;
   localparam int FLG_OV = 2;
   localparam int FLG_N  = 3;
endpackage

// File: rtl/div_flags_prep.sv
module div_flags_prep
   import div_flags_pkg::*;
#(
   parameter int W  = 32,
   parameter int HW = 16
) (
   input  logic [1:0]   op,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] mag_a,
   output logic [W-1:0] mag_b,
   output logic         neg_q,
   output logic         neg_r,
   output logic         is_zero,
   output logic         is_ovf
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

   logic           is_signed;
   logic           is_half;
   logic [W-1:0]   half_div;
   logic [W-1:0]   eff_div;
   logic           sgn_a;
   logic           sgn_b;

   assign is_signed = ~op[0];
   assign is_half   = op[1];

   generate
      if (HW < W) begin : g_narrow
         assign half_div = is_signed ? {{(W-HW){divisor[HW-1]}}, divisor[HW-1:0]}
                                     : {{(W-HW){1'b0}}, divisor[HW-1:0]};
      end else begin : g_full
         assign half_div = divisor;
      end
   endgenerate

   always_comb begin
      eff_div = is_half ? half_div : divisor;
      sgn_a   = is_signed & dividend[W-1];
      sgn_b   = is_signed & eff_div[W-1];
      mag_a   = sgn_a ? (~dividend + 1'b1) : dividend;
      mag_b   = sgn_b ? (~eff_div + 1'b1) : eff_div;
      neg_q   = sgn_a ^ sgn_b;
      neg_r   = sgn_a;
      is_zero = (eff_div == '0);
      is_ovf  = is_signed && (dividend == MOST_NEG) && (&eff_div);
   end
endmodule

// File: rtl/div_flags_core.sv
module div_flags_core #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] mag_a,
   input  logic [W-1:0] mag_b,
   output logic [W-1:0] nxt_q,
   output logic [W-1:0] nxt_r,
   output logic         last
);
   localparam int            CW    = $clog2(W);
   localparam logic [CW-1:0] LASTC = CW'(W - 1);

   logic [W-1:0]  rem_r;
   logic [W-1:0]  quo_r;
   logic [W-1:0]  dvs_r;
   logic [CW-1:0] cnt_r;
   logic [W:0]    shifted;
   logic [W:0]    trial;

   always_comb begin
      shifted = {rem_r, quo_r[W-1]};
      trial   = shifted - {1'b0, dvs_r};
      if (!trial[W]) begin
         nxt_r = trial[W-1:0];
         nxt_q = {quo_r[W-2:0], 1'b1};
      end else begin
         nxt_r = shifted[W-1:0];
         nxt_q = {quo_r[W-2:0], 1'b0};
      end
      last = (cnt_r == LASTC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_r <= '0;
         quo_r <= '0;
         dvs_r <= '0;
         cnt_r <= '0;
      end else if (load) begin
         rem_r <= '0;
         quo_r <= mag_a;
         dvs_r <= mag_b;
         cnt_r <= '0;
      end else if (step) begin
         rem_r <= nxt_r;
         quo_r <= nxt_q;
         cnt_r <= cnt_r + 1'b1;
      end
   end
endmodule

// File: rtl/div_flags_post.sv
module div_flags_post #(
   parameter int W = 32
) (
   input  logic [W-1:0] mag_q,
   input  logic [W-1:0] mag_r,
   input  logic         neg_q,
   input  logic         neg_r,
   output logic [W-1:0] quot,
   output logic [W-1:0] rem,
   output logic         z,
   output logic         s
);
   always_comb begin
      quot = neg_q ? (~mag_q + 1'b1) : mag_q;
      rem  = neg_r ? (~mag_r + 1'b1) : mag_r;
      z    = (quot == '0);
      s    = quot[W-1];
   end
endmodule

// File: rtl/div_flags_unit.sv
module div_flags_unit
   import div_flags_pkg::*;
#(
   parameter int W  = 32,
   parameter int HW = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [1:0]   op_i,
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] quot_o,
   output logic [W-1:0] rem_o,
   output logic         quot_we_o,
   output logic         rem_we_o,
   output logic         flag_z_o,
   output logic         flag_s_o,
   output logic         flag_ov_o,
   output logic [2:0]   flag_we_o
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

   generate
      if (W < 4 || (W % 2) != 0) begin : g_bad_w
         $error("div_flags_unit: W must be even and at least 4");
      end
      if (HW < 1 || HW > W) begin : g_bad_hw
         $error("div_flags_unit: HW must lie in 1..W");
      end
   endgenerate

   logic [W-1:0] mag_a, mag_b, nxt_q, nxt_r, fin_q, fin_r;
   logic         neg_q, neg_r, is_zero, is_ovf, last;
   logic         fin_z, fin_s;
   logic         busy_r, neg_q_r, neg_r_r;
   logic         accept, load_core;

   assign accept    = start_i && !busy_r;
   assign load_core = accept && !is_zero && !is_ovf;

   div_flags_prep #(.W(W), .HW(HW)) u_prep (
      .op       (op_i),
      .dividend (dividend_i),
      .divisor  (divisor_i),
      .mag_a    (mag_a),
      .mag_b    (mag_b),
      .neg_q    (neg_q),
      .neg_r    (neg_r),
      .is_zero  (is_zero),
      .is_ovf   (is_ovf)
   );

   div_flags_core #(.W(W)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_core),
      .step  (busy_r),
      .mag_a (mag_a),
      .mag_b (mag_b),
      .nxt_q (nxt_q),
      .nxt_r (nxt_r),
      .last  (last)
   );

   div_flags_post #(.W(W)) u_post (
      .mag_q (nxt_q),
      .mag_r (nxt_r),
      .neg_q (neg_q_r),
      .neg_r (neg_r_r),
      .quot  (fin_q),
      .rem   (fin_r),
      .z     (fin_z),
      .s     (fin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_r    <= 1'b0;
         neg_q_r   <= 1'b0;
         neg_r_r   <= 1'b0;
         done_o    <= 1'b0;
         quot_o    <= '0;
         rem_o     <= '0;
         quot_we_o <= 1'b0;
         rem_we_o  <= 1'b0;
         flag_z_o  <= 1'b0;
         flag_s_o  <= 1'b0;
         flag_ov_o <= 1'b0;
         flag_we_o <= '0;
      end else if (accept && is_zero) begin
         done_o    <= 1'b1;
         quot_we_o <= 1'b0;
         rem_we_o  <= 1'b0;
         flag_z_o  <= 1'b0;
         flag_s_o  <= 1'b0;
         flag_ov_o <= 1'b1;
         flag_we_o <= 3'b1 << FLG_OV;
      end else if (accept && is_ovf) begin
         done_o    <= 1'b1;
         quot_o    <= MOST_NEG;
         rem_o     <= '0;
         quot_we_o <= 1'b1;
         rem_we_o  <= 1'b1;
         flag_z_o  <= 1'b0;
         flag_s_o  <= 1'b1;
         flag_ov_o <= 1'b1;
         flag_we_o <= '1;
      end else if (accept) begin
         busy_r    <= 1'b1;
         neg_q_r   <= neg_q;
         neg_r_r   <= neg_r;
         done_o    <= 1'b0;
         quot_we_o <= 1'b0;
         rem_we_o  <= 1'b0;
         flag_we_o <= '0;
      end else if (busy_r && last) begin
         busy_r    <= 1'b0;
         done_o    <= 1'b1;
         quot_o    <= fin_q;
         rem_o     <= fin_r;
         quot_we_o <= 1'b1;
         rem_we_o  <= 1'b1;
         flag_z_o  <= fin_z;
         flag_s_o  <= fin_s;
         flag_ov_o <= 1'b0;
         flag_we_o <= '1;
      end else begin
         done_o    <= 1'b0;
         quot_we_o <= 1'b0;
         rem_we_o  <= 1'b0;
         flag_we_o <= '0;
      end
   end

   assign busy_o = busy_r;
endmodule

// File: rtl/div_flags_chk.sv
module div_flags_chk #(
   parameter int W  = 32,
   parameter int HW = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic [1:0]   op_i,
   input logic [W-1:0] dividend_i,
   input logic [W-1:0] divisor_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [W-1:0] quot_o,
   input logic [W-1:0] rem_o,
   input logic         quot_we_o,
   input logic         rem_we_o,
   input logic         flag_z_o,
   input logic         flag_s_o,
   input logic         flag_ov_o,
   input logic [2:0]   flag_we_o
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] ck_div;
   logic         ck_signed, ck_acc, ck_zero, ck_ovf, ck_norm;
   logic         trk_r;
   logic [15:0]  lat_r;

   always_comb begin
      ck_signed = (op_i == 2'd0) || (op_i == 2'd2);
      if (op_i[1])
         ck_div = ck_signed ? W'($signed(divisor_i[HW-1:0])) : W'(divisor_i[HW-1:0]);
      else
         ck_div = divisor_i;
      ck_acc  = start_i && !busy_o;
      ck_zero = ck_acc && (ck_div == '0);
      ck_ovf  = ck_acc && ck_signed && (dividend_i == MOST_NEG) && (ck_div == '1);
      ck_norm = ck_acc && !ck_zero && !ck_ovf;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trk_r <= 1'b0;
         lat_r <= '0;
      end else if (ck_norm) begin
         trk_r <= 1'b1;
         lat_r <= '0;
      end else if (trk_r && done_o) begin
         trk_r <= 1'b0;
      end else if (trk_r) begin
         lat_r <= lat_r + 1'b1;
      end
   end

   AST_ZERO_DIV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ck_zero |=> done_o && !quot_we_o && !rem_we_o && flag_ov_o && flag_we_o == 3'b100); // R5

   AST_MIN_BY_NEG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ck_ovf |=> done_o && quot_o == MOST_NEG && rem_o == '0 && quot_we_o && rem_we_o
                 && !flag_z_o && flag_s_o && flag_ov_o && flag_we_o == 3'b111); // R6

   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      ck_norm |=> busy_o && !done_o); // R7

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (trk_r && done_o) |-> lat_r == 16'(W)); // R7

   AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> (busy_o || done_o)); // R8

   AST_WE_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (quot_we_o || rem_we_o || flag_we_o != 3'b000) |-> done_o); // R9

   AST_NORMAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && quot_we_o && !flag_ov_o) |->
         flag_z_o == (quot_o == '0) && flag_s_o == quot_o[W-1] && flag_we_o == 3'b111); // R4
endmodule

bind div_flags_unit div_flags_chk #(.W(W), .HW(HW)) u_chk (.*);

// File: tb/sim_div_flags_unit.sv
`timescale 1ns/1ps
module sim_div_flags_unit;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    op_i = '0;
   logic [W-1:0]  dividend_i = '0;
   logic [W-1:0]  divisor_i = '0;
   logic          busy_o, done_o, quot_we_o, rem_we_o, flag_z_o, flag_s_o, flag_ov_o;
   logic [W-1:0]  quot_o, rem_o;
   logic [2:0]    flag_we_o;

   typedef struct {
      logic [W-1:0] q;
      logic [W-1:0] r;
      logic         qwe;
      logic         rwe;
      logic [2:0]   fwe;
      logic         z;
      logic         s;
      logic         ov;
      int           cyc;
      string        tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   int   cyc     = 0;
   int   n_issued = 0;
   int   n_done   = 0;
   bit   wd_fired = 0;

   div_flags_unit u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .dividend_i(dividend_i), .divisor_i(divisor_i), .busy_o(busy_o),
      .done_o(done_o), .quot_o(quot_o), .rem_o(rem_o), .quot_we_o(quot_we_o),
      .rem_we_o(rem_we_o), .flag_z_o(flag_z_o), .flag_s_o(flag_s_o),
      .flag_ov_o(flag_ov_o), .flag_we_o(flag_we_o)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input string tag);
      exp_t e;
      logic [W-1:0] eb;
      logic signed [W-1:0] sa, sbv;
      bit sgn;
      @(negedge clk);
      while (busy_o) @(negedge clk);
      sgn = (op == 2'd0) || (op == 2'd2);
      if (op[1]) eb = sgn ? {{16{b[15]}}, b[15:0]} : {16'h0, b[15:0]};
      else       eb = b;
      e.tag = tag;
      if (eb == '0) begin
         e.q = '0; e.r = '0; e.qwe = 0; e.rwe = 0; e.fwe = 3'b100;
         e.z = 0; e.s = 0; e.ov = 1; e.cyc = cyc + 1;
      end else if (sgn && a == 32'h8000_0000 && eb == 32'hFFFF_FFFF) begin
         e.q = 32'h8000_0000; e.r = '0; e.qwe = 1; e.rwe = 1; e.fwe = 3'b111;
         e.z = 0; e.s = 1; e.ov = 1; e.cyc = cyc + 1;
      end else begin
         if (sgn) begin
            sa = a; sbv = eb;
            e.q = sa / sbv;
            e.r = sa % sbv;
         end else begin
            e.q = a / eb;
            e.r = a % eb;
         end
         e.qwe = 1; e.rwe = 1; e.fwe = 3'b111;
         e.z = (e.q == '0); e.s = e.q[W-1]; e.ov = 0; e.cyc = cyc + 1 + W;
      end
      start_i = 1'b1; op_i = op; dividend_i = a; divisor_i = b;
      sb_q.push_back(e);
      n_issued++;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && !wd_fired) begin
         if (done_o) begin
            n_done++;
            if (sb_q.size() == 0) begin
               check(0, "R8", "unexpected done", 32'(done_o), 32'h0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(cyc == e.cyc, e.tag, "done cycle", 32'(cyc), 32'(e.cyc));
               check(quot_we_o == e.qwe && rem_we_o == e.rwe, e.tag, "write enables",
                     {30'h0, quot_we_o, rem_we_o}, {30'h0, e.qwe, e.rwe});
               check(flag_we_o == e.fwe, e.tag, "flag mask", 32'(flag_we_o), 32'(e.fwe));
               if (e.qwe) begin
                  check(quot_o == e.q, e.tag, "quotient", quot_o, e.q);
                  check(rem_o == e.r, e.tag, "remainder", rem_o, e.r);
               end
               if (e.fwe[0]) check(flag_z_o == e.z, e.tag, "zero flag", 32'(flag_z_o), 32'(e.z));
               if (e.fwe[1]) check(flag_s_o == e.s, e.tag, "sign flag", 32'(flag_s_o), 32'(e.s));
               if (e.fwe[2]) check(flag_ov_o == e.ov, e.tag, "overflow flag", 32'(flag_ov_o), 32'(e.ov));
            end
         end else if (quot_we_o || rem_we_o || flag_we_o != 3'b000) begin
            check(0, "R9", "enable without done", {29'h0, flag_we_o}, 32'h0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      wd_fired = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!done_o && !busy_o && !quot_we_o && !rem_we_o && flag_we_o == 3'b000,
            "R9", "reset state", {27'h0, done_o, busy_o, quot_we_o, rem_we_o, 1'b0}, 32'h0);
      rst_n = 1'b1;
      // R1 unsigned word
      issue(2'd1, 32'd100, 32'd7, "R1");
      issue(2'd1, 32'hFFFF_FFFF, 32'd3, "R1");
      issue(2'd1, 32'h8000_0000, 32'hFFFF_FFFF, "R1");
      // R4 zero quotient sets zero flag
      issue(2'd1, 32'd5, 32'd10, "R4");
      issue(2'd0, 32'd0, 32'd5, "R4");
      // R2 signed truncation
      issue(2'd0, -32'sd7, 32'd2, "R2");
      issue(2'd0, 32'd7, -32'sd2, "R2");
      issue(2'd0, -32'sd7, -32'sd2, "R2");
      issue(2'd0, 32'h8000_0000, 32'd1, "R2");
      // R3 halfword divisor narrowing
      issue(2'd2, 32'd100, 32'h1234_FFFE, "R3");
      issue(2'd3, 32'd100, 32'h1234_FFFE, "R3");
      issue(2'd3, 32'h8000_0000, 32'h0000_FFFF, "R3");
      issue(2'd2, 32'hF000_0000, 32'hFFFF_0003, "R3");
      // R5 divide by zero
      issue(2'd0, 32'd55, 32'd0, "R5");
      issue(2'd1, 32'd55, 32'd0, "R5");
      issue(2'd2, 32'd55, 32'hABCD_0000, "R5");
      issue(2'd3, 32'd55, 32'hABCD_0000, "R5");
      // R6 most negative by minus one
      issue(2'd0, 32'h8000_0000, 32'hFFFF_FFFF, "R6");
      issue(2'd2, 32'h8000_0000, 32'h0000_FFFF, "R6");
      // R7 back-to-back ordinary after special
      issue(2'd1, 32'd1000, 32'd0, "R5");
      issue(2'd1, 32'd1000, 32'd9, "R7");
      // R8 start while busy ignored
      issue(2'd1, 32'd12345, 32'd11, "R8");
      repeat (3) @(negedge clk);
      start_i = 1'b1; op_i = 2'd0; dividend_i = 32'd9; divisor_i = 32'd0;
      @(negedge clk);
      start_i = 1'b0;
      repeat (10) @(negedge clk);
      start_i = 1'b1; op_i = 2'd1; dividend_i = 32'd1; divisor_i = 32'd1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      while (busy_o || sb_q.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      check(n_done == n_issued, "R8", "done count", 32'(n_done), 32'(n_issued));
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule